// File: doc/BRIEF.md
# Diagonal-Scan Round-Robin Crossbar Matcher

This block is the central scheduler of an input-queued cell switch with N inputs and N outputs. Each slot it takes an N×N request matrix, one bit per input/output pair, and returns a transfer matrix in which no input and no output is used twice. It is the switching-matrix scheduler only. It reads a request as a plain nonzero flag, and queue storage and the fabric belong to other blocks.

The matcher walks the matrix along N wrapped diagonals. Diagonal d holds the positions (row i, column (i+d) mod N) for every row i. Two positions on the same diagonal never share a row or a column, and the N diagonals together cover each matrix position exactly once. In each step one diagonal is examined. Every request on it whose row and column are both still unclaimed is granted, and that row and column are then closed to the remaining steps. After N steps the result is final. The diagonal that opens the scan moves forward by one after every scan, so no input/output pair keeps a lasting advantage.

Use: pulse `start_i` for one cycle with the request matrix on `req_i`. The matrix is captured on that edge and later changes on `req_i` have no effect. `busy_o` stays high for the N scan cycles. `done_o` pulses when `grant_o` holds the finished match, and `grant_o` keeps that value until the next accepted start.

Top module: `diag_rr_matcher`

## Requirements
- R1: After reset `busy_o`, `done_o` and `grant_o` are all zero, and the first scan opens on diagonal 0.
- R2: `grant_o` only contains pairs that were requested in the matrix captured at the accepted start. Changes on `req_i` after that edge do not affect the result.
- R3: In `grant_o` each row (input) has at most one bit set, and each column (output) has at most one bit set.
- R4: Scan step k (k = 0..N-1) examines diagonal (s+k) mod N, where s is the opening diagonal of that scan and diagonal d is the set of positions (i, (i+d) mod N). A request is granted if and only if its row and its column are both unclaimed when its diagonal is examined.
- R5: When `done_o` is high, every requested pair that was not granted has its row or its column already granted (the match is maximal).
- R6: A start sampled high on a clock edge while idle makes `busy_o` high for exactly N cycles. `done_o` is high for exactly one cycle, N+1 clock edges after the start edge, and `busy_o` is low in that cycle.
- R7: The opening diagonal advances by one, modulo N, after every completed scan.
- R8: `start_i` is ignored while `busy_o` is high: no extra scan is started, no extra `done_o` pulse occurs, and the result of the scan in progress is unchanged. `grant_o` holds its value until the next accepted start.
- R9: Bit i*N+j of `req_i` and of `grant_o` stands for input (row) i to output (column) j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request to begin a scan; captures `req_i` |
| req_i | input | N*N | Request matrix, bit i*N+j for input i to output j |
| busy_o | output | 1 | High while a scan is running |
| done_o | output | 1 | One-cycle pulse when `grant_o` holds the finished match |
| grant_o | output | N*N | Transfer matrix, same bit layout as `req_i` |

## Verification
A full request matrix shows which diagonal opens each scan, because the whole opening diagonal is granted and nothing else. Repeating it over N scans in a row therefore exposes the rotation of the opening diagonal. A matrix where every input asks for the same output shows which row claims a contested column first, and so checks the scan order. A single request at a known position pins down the bit layout, and an empty matrix must give an empty result. Randomly filled matrices are compared against a greedy diagonal walk computed in the bench, and are also checked for one grant per row and column and for maximality. Changing `req_i` and pulsing `start_i` during a scan show that both are ignored.

// File: rtl/diag_pkg.sv
package diag_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_SCAN = 1'b1
  } phase_e;

  // Width of an index into 0..n-1 (at least one bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // (a + b) mod n for operands already below n.
  function automatic int wrap_sum(input int a, input int b, input int n);
    int s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/diag_rst_sync.sv
module diag_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/diag_sequencer.sv
module diag_sequencer #(
  parameter int N = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start_i,
  output logic                                busy_o,
  output logic                                load_o,
  output logic                                scan_o,
  output logic [diag_pkg::idx_width(N)-1:0]   diag_o,
  output logic                                done_o
);
  import diag_pkg::*;

  localparam int IW = idx_width(N);
  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);
  localparam logic [IW:0]   N_W      = (IW + 1)'(N);

  phase_e        phase_q, phase_d;
  logic [IW-1:0] step_q, step_d;
  logic [IW-1:0] base_q, base_d;
  logic          done_q, done_d;
  logic          step_en, base_en;
  logic          last_step;
  logic [IW:0]   diag_sum;
  logic [IW:0]   diag_wrapped;

  assign busy_o    = (phase_q == PH_SCAN);
  assign load_o    = start_i && (phase_q == PH_IDLE);
  assign scan_o    = (phase_q == PH_SCAN);
  assign last_step = scan_o && (step_q == LAST_IDX);

  // Diagonal handled in the current step: (base + step) mod N.
  assign diag_sum     = {1'b0, base_q} + {1'b0, step_q};
  assign diag_wrapped = (diag_sum >= N_W) ? (diag_sum - N_W) : diag_sum;
  assign diag_o       = diag_wrapped[IW-1:0];

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    base_d  = base_q;
    done_d  = 1'b0;
    step_en = 1'b0;
    base_en = 1'b0;
    if (load_o) begin
      phase_d = PH_SCAN;
      step_d  = '0;
      step_en = 1'b1;
    end else if (scan_o) begin
      step_d  = step_q + 1'b1;
      step_en = 1'b1;
      if (last_step) begin
        phase_d = PH_IDLE;
        done_d  = 1'b1;
        base_en = 1'b1;
        base_d  = (base_q == LAST_IDX) ? '0 : base_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      base_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
      if (step_en) step_q <= step_d;
      if (base_en) base_q <= base_d;
    end
  end

  assign done_o = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_o && step_q == LAST_IDX) |=> (done_q && !busy_o)); // R6

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_o && step_q != LAST_IDX) |=> (scan_o && step_q == $past(step_q) + 1'b1)); // R8

  AST_BASE_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (base_q == (($past(base_q) == LAST_IDX) ? '0 : $past(base_q) + 1'b1))); // R7

  AST_BASE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(base_q)); // R7

endmodule

// File: rtl/diag_step_unit.sv
module diag_step_unit #(
  parameter int N = 4
) (
  input  logic [diag_pkg::idx_width(N)-1:0] diag_i,
  input  logic [N*N-1:0]                    req_i,
  input  logic [N-1:0]                      row_free_i,
  input  logic [N-1:0]                      col_free_i,
  output logic [N*N-1:0]                    take_o,
  output logic [N-1:0]                      row_used_o,
  output logic [N-1:0]                      col_used_o
);
  import diag_pkg::*;

  // All positions of one diagonal are disjoint in row and column,
  // so every row is evaluated in parallel.
  always_comb begin
    take_o     = '0;
    row_used_o = '0;
    col_used_o = '0;
    for (int r = 0; r < N; r++) begin
      int c;
      c = wrap_sum(r, int'(diag_i), N);
      if (req_i[r*N + c] && row_free_i[r] && col_free_i[c]) begin
        take_o[r*N + c] = 1'b1;
        row_used_o[r]   = 1'b1;
        col_used_o[c]   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/diag_rr_matcher.sv
module diag_rr_matcher #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [N*N-1:0] req_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [N*N-1:0] grant_o
);
  import diag_pkg::*;

  localparam int NN = N * N;
  localparam int IW = idx_width(N);

  logic          rst_s_n;
  logic          load, scan, done;
  logic [IW-1:0] diag;

  logic [NN-1:0] req_q, req_d;
  logic [NN-1:0] grant_q, grant_d;
  logic [N-1:0]  row_free_q, row_free_d;
  logic [N-1:0]  col_free_q, col_free_d;
  logic          state_en;

  logic [NN-1:0] take;
  logic [N-1:0]  row_used;
  logic [N-1:0]  col_used;

  diag_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  diag_sequencer #(.N(N)) u_seq (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .load_o  (load),
    .scan_o  (scan),
    .diag_o  (diag),
    .done_o  (done)
  );

  diag_step_unit #(.N(N)) u_step (
    .diag_i     (diag),
    .req_i      (req_q),
    .row_free_i (row_free_q),
    .col_free_i (col_free_q),
    .take_o     (take),
    .row_used_o (row_used),
    .col_used_o (col_used)
  );

  always_comb begin
    req_d      = req_q;
    grant_d    = grant_q;
    row_free_d = row_free_q;
    col_free_d = col_free_q;
    state_en   = 1'b0;
    if (load) begin
      req_d      = req_i;
      grant_d    = '0;
      row_free_d = '1;
      col_free_d = '1;
      state_en   = 1'b1;
    end else if (scan) begin
      grant_d    = grant_q | take;
      row_free_d = row_free_q & ~row_used;
      col_free_d = col_free_q & ~col_used;
      state_en   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      req_q      <= '0;
      grant_q    <= '0;
      row_free_q <= '0;
      col_free_q <= '0;
    end else if (state_en) begin
      req_q      <= req_d;
      grant_q    <= grant_d;
      row_free_q <= row_free_d;
      col_free_q <= col_free_d;
    end
  end

  assign done_o  = done;
  assign grant_o = grant_q;

  // Column-major copy of the grant matrix for the column checks.
  logic [NN-1:0] grant_t;
  for (genvar gr = 0; gr < N; gr++) begin : g_tr_row
    for (genvar gc = 0; gc < N; gc++) begin : g_tr_col
      assign grant_t[gc*N + gr] = grant_q[gr*N + gc];
    end
  end

  AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_s_n)
    (grant_q & ~req_q) == '0); // R2

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy_o |=> $stable(req_q)); // R2

  AST_GRANT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!busy_o && !load) |=> $stable(grant_q)); // R8

  for (genvar gi = 0; gi < N; gi++) begin : g_one_hot
    AST_ROW_ONE: assert property (@(posedge clk) disable iff (!rst_s_n)
      $onehot0(grant_q[gi*N +: N])); // R3
    AST_COL_ONE: assert property (@(posedge clk) disable iff (!rst_s_n)
      $onehot0(grant_t[gi*N +: N])); // R3
  end

  for (genvar mr = 0; mr < N; mr++) begin : g_max_row
    for (genvar mc = 0; mc < N; mc++) begin : g_max_col
      AST_MAXIMAL: assert property (@(posedge clk) disable iff (!rst_s_n)
        (done && req_q[mr*N + mc] && !grant_q[mr*N + mc])
          |-> ((|grant_q[mr*N +: N]) || (|grant_t[mc*N +: N]))); // R5
    end
  end

endmodule

// File: tb/diag_rr_matcher_tb.sv
`timescale 1ns/1ps
module diag_rr_matcher_tb;

  localparam int N  = 4;
  localparam int NN = N * N;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [NN-1:0] req_i;
  logic          busy_o;
  logic          done_o;
  logic [NN-1:0] grant_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int sd     = 0;   // bench copy of the opening diagonal
  bit finished = 0;

  logic [NN-1:0] exp_q[$];
  logic [NN-1:0] req_hist_q[$];
  int            t0_q[$];
  string         tag_q[$];
  logic [NN-1:0] last_exp;

  diag_rr_matcher #(.N(N)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .req_i   (req_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .grant_o (grant_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Greedy diagonal walk from the requirements (R4).
  function automatic logic [NN-1:0] ref_match(input logic [NN-1:0] r, input int s);
    logic [N-1:0]  rf;
    logic [N-1:0]  cf;
    logic [NN-1:0] g;
    rf = '1; cf = '1; g = '0;
    for (int k = 0; k < N; k++) begin
      int d;
      d = (s + k) % N;
      for (int i = 0; i < N; i++) begin
        int j;
        j = (i + d) % N;
        if (r[i*N + j] && rf[i] && cf[j]) begin
          g[i*N + j] = 1'b1;
          rf[i] = 1'b0;
          cf[j] = 1'b0;
        end
      end
    end
    return g;
  endfunction

  function automatic logic [NN-1:0] diag_mask(input int d);
    logic [NN-1:0] m;
    m = '0;
    for (int i = 0; i < N; i++) m[i*N + (i + d) % N] = 1'b1;
    return m;
  endfunction

  // Driver: issue one start, push the expected result.
  task automatic push_start(input logic [NN-1:0] r, input string tag);
    @(negedge clk);
    start_i = 1'b1;
    req_i   = r;
    exp_q.push_back(ref_match(r, sd));
    req_hist_q.push_back(r);
    t0_q.push_back(cyc);
    tag_q.push_back(tag);
    last_exp = ref_match(r, sd);
    sd = (sd + 1) % N;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic run_scan(input logic [NN-1:0] r, input string tag);
    push_start(r, tag);
    wait_idle();
  endtask

  // Monitor: pop and compare on every done pulse.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R8 unexpected done actual=1 expected=0");
      end else begin
        logic [NN-1:0] e;
        logic [NN-1:0] rq;
        int t0;
        string tg;
        e  = exp_q.pop_front();
        rq = req_hist_q.pop_front();
        t0 = t0_q.pop_front();
        tg = tag_q.pop_front();
        check(tg, "grant matrix (R4)", 64'(grant_o), 64'(e));
        check("R6", "start-to-done edges", 64'(cyc - t0), 64'(N + 1));
        check("R6", "busy low at done", 64'(busy_o), 64'd0);
        // R3: one grant per row and per column
        begin
          int bad;
          bad = 0;
          for (int i = 0; i < N; i++) begin
            int rc, cc;
            rc = 0; cc = 0;
            for (int j = 0; j < N; j++) begin
              rc += int'(grant_o[i*N + j]);
              cc += int'(grant_o[j*N + i]);
            end
            if (rc > 1 || cc > 1) bad++;
          end
          check("R3", "rows/cols with more than one grant", 64'(bad), 64'd0);
        end
        // R2 and R5: subset of requests and maximal
        check("R2", "grants outside requests", 64'(grant_o & ~rq), 64'd0);
        begin
          int miss;
          miss = 0;
          for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
              if (rq[i*N + j] && !grant_o[i*N + j] &&
                  !(|grant_o[i*N +: N]) && !(|(grant_o & ({NN{1'b0}} | col_bits(j)))))
                miss++;
          check("R5", "addable pairs left", 64'(miss), 64'd0);
        end
      end
    end
  end

  function automatic logic [NN-1:0] col_bits(input int j);
    logic [NN-1:0] m;
    m = '0;
    for (int i = 0; i < N; i++) m[i*N + j] = 1'b1;
    return m;
  endfunction

  task automatic finish_run();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog expired actual=hung expected=idle");
      finish_run();
    end
  end

  initial begin
    start_i = 1'b0;
    req_i   = '0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "busy after reset", 64'(busy_o), 64'd0);
    check("R1", "done after reset", 64'(done_o), 64'd0);
    check("R1", "grant after reset", 64'(grant_o), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "idle after release", 64'(busy_o), 64'd0);

    // R1/R4: first scan opens on diagonal 0 -> full matrix grants diagonal 0
    run_scan('1, "R1");
    @(negedge clk);
    check("R1", "first scan picks diagonal 0", 64'(grant_o), 64'(diag_mask(0)));

    // R7: consecutive full matrices step through diagonals 1,2,3,0
    for (int k = 1; k <= N; k++) begin
      run_scan('1, "R7");
      @(negedge clk);
      check("R7", "opening diagonal rotates", 64'(grant_o), 64'(diag_mask(k % N)));
    end

    // R4: empty matrix
    run_scan('0, "R4");
    // R4: every input wants output 0
    run_scan(col_bits(0), "R4");
    run_scan(col_bits(2), "R4");
    // R4: only diagonal 0 requested
    run_scan(diag_mask(0), "R4");

    // R9: single request input 1 -> output 2 is bit 6
    run_scan(NN'(1) << (1*N + 2), "R9");
    @(negedge clk);
    check("R9", "bit 1*N+2 granted", 64'(grant_o), 64'(1) << 6);

    // R2: req_i changes during scan have no effect
    push_start(16'h8421 ^ 16'h00F0, "R2");
    req_i = '1;
    @(negedge clk);
    req_i = 16'h1248;
    wait_idle();

    // R8: start during a busy scan is ignored
    push_start(16'hA5C3, "R8");
    start_i = 1'b1;
    req_i   = '1;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    repeat (N + 3) @(negedge clk);
    check("R8", "no second scan", 64'(busy_o), 64'd0);
    check("R8", "grant held after scan", 64'(grant_o), 64'(last_exp));

    // Random matrices
    for (int n = 0; n < 24; n++) begin
      run_scan(NN'($urandom), "R4");
    end

    repeat (4) @(negedge clk);
    check("R8", "no pending results", 64'(exp_q.size()), 64'd0);
    finish_run();
  end

endmodule